// File: doc/BRIEF.md
# Register Write Hazard Scoreboard

This block tracks the destination registers of instructions that have passed register fetch in an in-order pipeline and have not yet written their results back. Each instruction that leaves register fetch records its destination in the next free slot. The write-back stage releases slots strictly oldest first. An instruction that was poisoned on a wrong path still reaches write-back and releases its slot there, so only one stage ever removes entries.

Register fetch presents the two source register indices of the instruction it holds. The block raises a stall when either index matches a destination that is still pending. A release in the same cycle is applied before the search, so the instruction retiring this cycle no longer holds up its consumer. An instruction with no destination, or one that writes register 0, still takes a slot but never matches a search. The slot count is a parameter, and a full flag tells register fetch when it may not insert.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset all slots are empty: `full` is 0 and `stall` is 0 for every pair of source indices.
- R2: `stall` is 1 when `src_a` or `src_b` equals the destination of a pending slot that is tracked.
- R3: A slot inserted with `ins_has_dst` = 0, or with `ins_dst` = 0, never causes a stall, and a source index of 0 never causes a stall.
- R4: Slots are released in insertion order: each `rem_valid` frees the oldest pending slot.
- R5: When `rem_valid` is 1 and a slot is pending, the oldest slot is left out of that cycle's search, so its destination alone does not stall.
- R6: `full` is 1 exactly when `DEPTH` slots are pending.
- R7: An insert while `full` is 1 and `rem_valid` is 0 is dropped; its destination never causes a stall.
- R8: An insert and a release in the same cycle are both carried out, and the number of pending slots stays the same, so `full` keeps its value.
- R9: A `rem_valid` while no slot is pending has no effect.
- R10: When several pending slots hold the same destination, the stall on that register lasts until the youngest of them is released or left out of the search under R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Record the destination of an instruction leaving register fetch |
| ins_has_dst | input | 1 | The inserted instruction writes a register |
| ins_dst | input | REG_W | Destination register index of the inserted instruction |
| rem_valid | input | 1 | Write-back releases the oldest slot |
| src_a | input | REG_W | First source register index to search for |
| src_b | input | REG_W | Second source register index to search for |
| stall | output | 1 | A source matches a pending destination |
| full | output | 1 | All slots are pending |

## Verification
The assertions assume that register fetch does not depend on an insert being kept while `full` is high without a release. They also assume that write-back asserts `rem_valid` only for an instruction that really took a slot. The checks on counting and ordering nevertheless stay valid when either assumption is broken, because the block drops such requests by itself. The bench deliberately sends dropped inserts and releases on an empty block to exercise R7 and R9. Its random phase draws register indices from a small range so that matches, duplicate destinations and simultaneous insert and release happen often.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Next slot index in a ring of depth slots.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned depth);
    return (idx + 1 == depth) ? 0 : idx + 1;
  endfunction

  // An entry takes part in hazard checks only if it writes a non-zero register.
  function automatic logic is_tracked(input logic has_dst, input int unsigned dst);
    return has_dst && (dst != 0);
  endfunction

  // A tracked entry conflicts with a source when the indices are equal.
  function automatic logic src_conflict(input logic tracked, input int unsigned dst,
                                        input int unsigned src);
    return tracked && (dst == src);
  endfunction

endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic             rem_valid,
  output logic             do_ins,
  output logic             do_rem,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic             empty;

  assign empty  = (count_q == '0);
  assign full   = (count_q == CNT_W'(DEPTH));
  assign do_rem = rem_valid && !empty;
  assign do_ins = ins_valid && (!full || do_rem);
  assign head   = head_q;
  assign tail   = tail_q;
  assign count  = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_rem) head_q <= PTR_W'(sb_pkg::ring_next(32'(head_q), DEPTH));
      if (do_ins) tail_q <= PTR_W'(sb_pkg::ring_next(32'(tail_q), DEPTH));
      case ({do_ins, do_rem})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && full && !rem_valid) |=> (count_q == $past(count_q)));

  p_swap_keeps_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ins && do_rem) |=> (count_q == $past(count_q)));

  p_empty_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rem_valid && !ins_valid) |=> (count_q == '0) && $stable(head_q));

endmodule

// File: rtl/sb_slots.sv
module sb_slots #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned REG_W = 5,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_ins,
  input  logic             do_rem,
  input  logic [PTR_W-1:0] head,
  input  logic [PTR_W-1:0] tail,
  input  logic             ins_has_dst,
  input  logic [REG_W-1:0] ins_dst,
  output logic [DEPTH-1:0] occ,
  output logic [DEPTH-1:0] tracked,
  output logic [REG_W-1:0] dst [DEPTH]
);
  logic [DEPTH-1:0] occ_q, trk_q;
  logic [REG_W-1:0] dst_q [DEPTH];
  logic             ins_trk;

  assign ins_trk = sb_pkg::is_tracked(ins_has_dst, 32'(ins_dst));

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit_rem, hit_ins;
    assign hit_rem = do_rem && (head == PTR_W'(i));
    assign hit_ins = do_ins && (tail == PTR_W'(i));

    // Release is applied first so a slot reused in the same cycle stays occupied.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ_q[i] <= 1'b0;
        trk_q[i] <= 1'b0;
        dst_q[i] <= '0;
      end else if (hit_ins) begin
        occ_q[i] <= 1'b1;
        trk_q[i] <= ins_trk;
        dst_q[i] <= ins_dst;
      end else if (hit_rem) begin
        occ_q[i] <= 1'b0;
        trk_q[i] <= 1'b0;
      end
    end

    assign dst[i] = dst_q[i];
  end

  assign occ     = occ_q;
  assign tracked = trk_q;

  p_tracked_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    do_ins |=> !(tracked[$past(tail)] && dst[$past(tail)] == '0));

endmodule

// File: rtl/sb_search.sv
module sb_search #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned REG_W = 5,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] occ,
  input  logic [DEPTH-1:0] tracked,
  input  logic [REG_W-1:0] dst [DEPTH],
  input  logic             do_rem,
  input  logic [PTR_W-1:0] head,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  output logic [DEPTH-1:0] hits,
  output logic             stall
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic live;
    // The slot being released this cycle is invisible to the search.
    assign live = occ[i] && !(do_rem && head == PTR_W'(i));
    assign hits[i] = live &&
      (sb_pkg::src_conflict(tracked[i], 32'(dst[i]), 32'(src_a)) ||
       sb_pkg::src_conflict(tracked[i], 32'(dst[i]), 32'(src_b)));
  end

  assign stall = |hits;

  always_comb begin
    p_zero_src_r3: assert (!((src_a == '0) && (src_b == '0) && stall));
  end

endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic             ins_has_dst,
  input  logic [REG_W-1:0] ins_dst,
  input  logic             rem_valid,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  output logic             stall,
  output logic             full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             do_ins, do_rem;
  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic [DEPTH-1:0] occ, tracked, hits;
  logic [REG_W-1:0] dst [DEPTH];

  sb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .rem_valid(rem_valid),
    .do_ins(do_ins), .do_rem(do_rem), .head(head), .tail(tail),
    .count(count), .full(full)
  );

  sb_slots #(.DEPTH(DEPTH), .REG_W(REG_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .do_ins(do_ins), .do_rem(do_rem),
    .head(head), .tail(tail), .ins_has_dst(ins_has_dst), .ins_dst(ins_dst),
    .occ(occ), .tracked(tracked), .dst(dst)
  );

  sb_search #(.DEPTH(DEPTH), .REG_W(REG_W)) u_search (
    .occ(occ), .tracked(tracked), .dst(dst), .do_rem(do_rem), .head(head),
    .src_a(src_a), .src_b(src_b), .hits(hits), .stall(stall)
  );

  p_occ_matches_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ) == 32'(count));

  p_head_is_oldest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |-> occ[head]);

  p_release_frees_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rem && !do_ins) |=> !occ[$past(head)]);

  p_released_not_searched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_rem |-> !hits[head]);

endmodule

// File: tb/reg_scoreboard_test.sv
`timescale 1ns/1ps
module reg_scoreboard_test;
  localparam int DEPTH = 4;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0, ins_has_dst = 1'b0, rem_valid = 1'b0;
  logic [REG_W-1:0] ins_dst = '0, src_a = '0, src_b = '0;
  logic stall, full;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int q[$];   // pending destinations, oldest first; -1 = never matches

  always #2.5 clk = ~clk;

  reg_scoreboard #(.DEPTH(DEPTH), .REG_W(REG_W)) uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_has_dst(ins_has_dst),
    .ins_dst(ins_dst), .rem_valid(rem_valid), .src_a(src_a), .src_b(src_b),
    .stall(stall), .full(full)
  );

  function automatic bit model_stall();
    int first = (rem_valid && q.size() > 0) ? 1 : 0;
    for (int i = first; i < q.size(); i++)
      if (q[i] >= 0 && (q[i] == int'(src_a) || q[i] == int'(src_b))) return 1;
    return 0;
  endfunction

  task automatic compare(input string tag);
    bit es = model_stall();
    bit ef = (q.size() == DEPTH);
    n_cmp++;
    if (stall !== es) begin
      n_bad++;
      $display("FAIL %s stall: actual %0b expected %0b", tag, stall, es);
    end
    n_cmp++;
    if (full !== ef) begin
      n_bad++;
      $display("FAIL %s full: actual %0b expected %0b", tag, full, ef);
    end
  endtask

  task automatic step(input bit iv, input bit hd, input int d, input bit rv,
                      input int sa, input int sb, input string tag);
    bit rem_eff;
    int sz;
    ins_valid = iv; ins_has_dst = hd; ins_dst = REG_W'(d);
    rem_valid = rv; src_a = REG_W'(sa); src_b = REG_W'(sb);
    #1;
    compare(tag);
    @(posedge clk);
    sz = q.size();
    rem_eff = rv && sz > 0;
    if (rem_eff) void'(q.pop_front());
    if (iv && (sz < DEPTH || rem_eff)) q.push_back((hd && d != 0) ? d : -1);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    step(0, 0, 0, 0, 5, 9, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 0, 0, 1, 31, "R1");

    step(1, 1, 5, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 5, 0, "R2");
    step(0, 0, 0, 0, 0, 5, "R2");
    step(0, 0, 0, 0, 6, 4, "R2");

    step(1, 0, 7, 0, 0, 0, "R3");
    step(1, 1, 0, 0, 7, 0, "R3");
    step(0, 0, 0, 0, 7, 0, "R3");
    step(0, 0, 0, 0, 0, 0, "R3");

    // head is 5: a release hides it from this cycle's search
    step(0, 0, 0, 1, 5, 0, "R5");
    step(0, 0, 0, 0, 5, 0, "R5");
    step(0, 0, 0, 1, 0, 0, "R4");
    step(0, 0, 0, 1, 0, 0, "R4");

    step(1, 1, 7, 0, 0, 0, "R4");
    step(1, 1, 8, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 8, 7, "R4");
    step(0, 0, 0, 0, 7, 0, "R4");
    step(0, 0, 0, 0, 8, 0, "R4");
    step(0, 0, 0, 1, 0, 0, "R4");

    for (int i = 1; i <= DEPTH; i++) step(1, 1, i, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 3, 0, "R6");
    step(1, 1, 9, 0, 9, 0, "R7");
    step(0, 0, 0, 0, 9, 0, "R7");
    step(1, 1, 12, 1, 12, 1, "R8");
    step(0, 0, 0, 0, 12, 0, "R8");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 9, 12, "R7");
    step(0, 0, 0, 0, 12, 9, "R7");

    step(0, 0, 0, 1, 3, 0, "R9");
    step(0, 0, 0, 0, 3, 0, "R9");
    step(1, 1, 3, 1, 0, 0, "R9");
    step(0, 0, 0, 0, 3, 0, "R9");
    step(0, 0, 0, 1, 3, 0, "R9");

    step(1, 1, 6, 0, 0, 0, "R10");
    step(1, 1, 6, 0, 0, 0, "R10");
    step(0, 0, 0, 1, 6, 0, "R10");
    step(0, 0, 0, 1, 6, 0, "R10");
    step(0, 0, 0, 0, 6, 0, "R10");

    for (int n = 0; n < 3000; n++) begin
      step($urandom_range(0, 1), $urandom_range(0, 3) != 0, $urandom_range(0, 7),
           $urandom_range(0, 2) == 0, $urandom_range(0, 7), $urandom_range(0, 7), "RND");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule